// File: doc/BRIEF.md
# Cycle-Stealing Block Copy Engine

This block copies a run of words from one region of a shared memory to another. The processor starts it by writing three setup values: the first source address, the first destination address and the number of words. It then writes a go register. From that point the copy runs in the background and needs no further help from the processor.

The engine shares a single memory port with the processor and never stalls it. In any cycle where the processor drives its memory request, the engine holds back. It uses only the idle cycles, one at a time. Each word takes two accesses in strict turn, and each access waits for its own free cycle. The read comes first. Its data comes back one cycle after the read is accepted and is held in a buffer. The write of that data to the destination follows. After every accepted write, both addresses step up by one and the remaining count steps down by one.

The engine has two status outputs. `busy_o` is high while a copy is in progress. `done_o` is a sticky flag set when the last word has been written, and it is cleared by the next go command.

Top module: `dma_steal`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `mem_req_o` are all low.
- R2: `mem_req_o` is never high in a cycle where `cpu_mem_req_i` is high. A stalled access is offered again, unchanged, in the next cycle.
- R3: Word k of a copy is read at address source+k and then written at address destination+k. The value written is the value seen on `mem_rdata_i` in the cycle after that read was accepted.
- R4: A copy of N words makes exactly N accepted reads and N accepted writes. After the copy, destination words 0..N-1 hold the source words 0..N-1.
- R5: `busy_o` goes high in the cycle after a go command that has a non-zero count. It stays high until the last write is accepted. It is never high at the same time as `done_o`.
- R6: `done_o` goes high with the edge that accepts the last write. It stays high until the next go command, which clears it.
- R7: A go command with a count of zero sets `done_o` in the next cycle. It makes no memory access, and `busy_o` stays low.
- R8: While `busy_o` is high, writes to any setup register and any go command are ignored. The copy in progress keeps its addresses and its word count.
- R9: Accesses alternate strictly: no two accepted reads occur without an accepted write between them, and no two accepted writes occur without an accepted read between them.
- R10: Register select codes on `cfg_sel_i` are: 0 for the source address, 1 for the destination address, 2 for the word count (its low CW bits), and 3 for go (data ignored). A go command is a write with select code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Setup register write strobe |
| cfg_sel_i | input | 2 | Register select (see R10) |
| cfg_wdata_i | input | AW | Setup write data |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | Sticky completion flag |
| cpu_mem_req_i | input | 1 | Processor uses the memory port this cycle |
| mem_req_o | output | 1 | Engine access this cycle |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Access address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, valid one cycle after an accepted read |

## Verification
Errors in the step logic show up as a misplaced address on `mem_addr_o`. This is visible at the first access after the faulty step, at most three free cycles after the word that went wrong. Errors in the count logic show up as an early or late `done_o`, or as the wrong number of accepted accesses. Losing the turn between read and write shows up as two reads in a row, or as stale buffer data written to the destination; a compare of the destination region catches the latter. A missing idle gate shows as `mem_req_o` high in a processor cycle. The bench drives busy patterns that are empty, alternating and pseudo-random, so a missing gate is exposed within the first few accesses.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD    = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WR    = 2'd3
  } xfer_st_e;

  localparam logic [1:0] SEL_SRC = 2'd0;
  localparam logic [1:0] SEL_DST = 2'd1;
  localparam logic [1:0] SEL_CNT = 2'd2;
  localparam logic [1:0] SEL_GO  = 2'd3;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  input  logic          busy_i,
  input  logic          step_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic          cnt_zero_o,
  output logic          cnt_last_o,
  output logic          go_o
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [AW-1:0] src_q, dst_q;
  logic [CW-1:0] cnt_q;
  logic          wr_ok;

  // setup writes are locked out while a copy runs
  assign wr_ok = cfg_we_i && !busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      dst_q <= '0;
      cnt_q <= '0;
    end else if (step_i) begin
      src_q <= src_q + AW'(1);
      dst_q <= dst_q + AW'(1);
      cnt_q <= cnt_q - CNT_ONE;
    end else if (wr_ok) begin
      case (cfg_sel_i)
        SEL_SRC: src_q <= cfg_wdata_i;
        SEL_DST: dst_q <= cfg_wdata_i;
        SEL_CNT: cnt_q <= cfg_wdata_i[CW-1:0];
        default: ;
      endcase
    end
  end

  assign src_o      = src_q;
  assign dst_o      = dst_q;
  assign cnt_zero_o = (cnt_q == '0);
  assign cnt_last_o = (cnt_q == CNT_ONE);
  assign go_o       = wr_ok && (cfg_sel_i == SEL_GO);

  AST_CFG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && cfg_we_i && !step_i) |=>
      (src_q == $past(src_q) && dst_q == $past(dst_q) && cnt_q == $past(cnt_q))); // R8
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          go_i,
  input  logic          cnt_zero_i,
  input  logic          cnt_last_i,
  input  logic [AW-1:0] src_i,
  input  logic [AW-1:0] dst_i,
  input  logic          cpu_mem_req_i,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          step_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o
);
  xfer_st_e      st_q, st_d;
  logic [DW-1:0] buf_q;
  logic          done_q;
  logic          want, grant;

  assign want  = (st_q == ST_RD) || (st_q == ST_WR);
  assign grant = want && !cpu_mem_req_i;   // steal only free cycles
  assign step_o = grant && (st_q == ST_WR);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (go_i && !cnt_zero_i) st_d = ST_RD;
      ST_RD:    if (grant) st_d = ST_RWAIT;
      ST_RWAIT: st_d = ST_WR;
      ST_WR:    if (grant) st_d = cnt_last_i ? ST_IDLE : ST_RD;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      buf_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_RWAIT) buf_q <= mem_rdata_i;
      if (go_i) done_q <= cnt_zero_i;
      else if (step_o && cnt_last_i) done_q <= 1'b1;
    end
  end

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = done_q;
  assign mem_req_o   = grant;
  assign mem_we_o    = (st_q == ST_WR);
  assign mem_addr_o  = (st_q == ST_WR) ? dst_i : src_i;
  assign mem_wdata_o = buf_q;

  // checker state: last accepted access was a read
  logic last_rd_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_rd_q <= 1'b0;
    else if (mem_req_o) last_rd_q <= !mem_we_o;
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o)); // R5
  AST_ZERO_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go_i && cnt_zero_i) |=> (done_o && !busy_o)); // R7
  AST_RD_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> !last_rd_q); // R9
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> last_rd_q); // R9
  AST_ADDR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(want && !mem_req_o) && want) |-> $stable(mem_addr_o)); // R2
endmodule

// File: rtl/dma_steal.sv
module dma_steal
  import dma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [AW-1:0] cfg_wdata_i,
  output logic          busy_o,
  output logic          done_o,
  input  logic          cpu_mem_req_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  logic [AW-1:0] src, dst;
  logic          cnt_zero, cnt_last, go, step;

  dma_cfg_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_wdata_i(cfg_wdata_i),
    .busy_i     (busy_o),
    .step_i     (step),
    .src_o      (src),
    .dst_o      (dst),
    .cnt_zero_o (cnt_zero),
    .cnt_last_o (cnt_last),
    .go_o       (go)
  );

  dma_xfer_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .cnt_zero_i   (cnt_zero),
    .cnt_last_i   (cnt_last),
    .src_i        (src),
    .dst_i        (dst),
    .cpu_mem_req_i(cpu_mem_req_i),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .step_o       (step),
    .mem_req_o    (mem_req_o),
    .mem_we_o     (mem_we_o),
    .mem_addr_o   (mem_addr_o),
    .mem_wdata_o  (mem_wdata_o)
  );

  AST_NO_ACCESS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o); // R7
endmodule

// File: tb/dma_steal_bench.sv
module dma_steal_bench;
  localparam int AW = 16;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [AW-1:0] cfg_wdata = '0;
  logic          busy, done;
  logic          cpu_req = 1'b0;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  dma_steal #(.AW(AW), .DW(DW), .CW(16)) u_dma_steal (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .busy_o(busy), .done_o(done),
    .cpu_mem_req_i(cpu_req),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] mem [256];

  // monitor state
  int            n_rd = 0, n_wr = 0, n_clash = 0, n_order = 0;
  logic [AW-1:0] exp_rd, exp_wr;
  logic [DW-1:0] last_rd_data;
  logic          want_read = 1'b1;

  always @(posedge clk) begin
    if (mem_req && cpu_req) n_clash++;
    if (mem_req && !mem_we) begin
      mem_rdata <= mem[mem_addr[7:0]];
      last_rd_data = mem[mem_addr[7:0]];
      n_rd++;
      if (!want_read || mem_addr != exp_rd) n_order++;
      exp_rd = exp_rd + 1'b1;
      want_read = 1'b0;
    end else if (mem_req && mem_we) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      n_wr++;
      if (want_read || mem_addr != exp_wr || mem_wdata != last_rd_data) n_order++;
      exp_wr = exp_wr + 1'b1;
      want_read = 1'b1;
    end
  end

  // processor activity: 0 none, 1 alternate, 2 pseudo-random
  int        cpu_mode = 0;
  logic [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    case (cpu_mode)
      1: cpu_req <= ~cpu_req;
      2: cpu_req <= lfsr[0] | lfsr[2];
      default: cpu_req <= 1'b0;
    endcase
  end

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] sel, logic [AW-1:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic wait_done(output int cycles);
    cycles = 0;
    while (!done && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  task automatic reset_monitor(logic [AW-1:0] s, logic [AW-1:0] d);
    n_rd = 0; n_wr = 0; n_clash = 0; n_order = 0;
    exp_rd = s; exp_wr = d; want_read = 1'b1;
  endtask

  task automatic t_reset;
    check("R1", "busy after reset", int'(busy), 0);
    check("R1", "done after reset", int'(done), 0);
    check("R1", "mem_req after reset", int'(mem_req), 0);
  endtask

  task automatic t_copy(int s, int d, int n, int mode);
    int cyc;
    for (int i = 0; i < n; i++) begin
      mem[(s + i) & 255] = DW'(i * 37 + 5 + s);
      mem[(d + i) & 255] = '0;
    end
    cpu_mode = mode;
    reset_monitor(AW'(s), AW'(d));
    cfg_write(2'd0, AW'(s));
    cfg_write(2'd1, AW'(d));
    cfg_write(2'd2, AW'(n));
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3; cfg_wdata = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R5", "busy after go", int'(busy), 1);
    check("R6", "done cleared by go", int'(done), 0);
    wait_done(cyc);
    check("R6", "done reached", int'(done), 1);
    check("R5", "busy low at done", int'(busy), 0);
    check("R4", "read count", n_rd, n);
    check("R4", "write count", n_wr, n);
    check("R2", "accesses in processor cycles", n_clash, 0);
    check("R3", "address/data order errors", n_order, 0);
    for (int i = 0; i < n; i++)
      check("R4", "dest word", int'(mem[(d + i) & 255]), int'(DW'(i * 37 + 5 + s)));
    repeat (3) @(negedge clk);
    check("R6", "done sticky", int'(done), 1);
    cpu_mode = 0;
  endtask

  task automatic t_zero;
    reset_monitor('0, '0);
    cfg_write(2'd2, '0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd3;
    @(negedge clk);
    cfg_we = 1'b0;
    check("R7", "done after zero go", int'(done), 1);
    check("R7", "busy after zero go", int'(busy), 0);
    repeat (4) @(negedge clk);
    check("R7", "accesses on zero go", n_rd + n_wr, 0);
  endtask

  task automatic t_lock;
    int cyc;
    for (int i = 0; i < 4; i++) begin
      mem[200 + i] = DW'(16'hC000 + i);
      mem[220 + i] = '0;
    end
    cpu_mode = 2;
    reset_monitor(AW'(200), AW'(220));
    cfg_write(2'd0, AW'(200));
    cfg_write(2'd1, AW'(220));
    cfg_write(2'd2, AW'(4));
    cfg_write(2'd3, '0);
    // all of these land while busy and must be dropped
    cfg_write(2'd0, AW'(10));
    cfg_write(2'd1, AW'(11));
    cfg_write(2'd2, AW'(40));
    cfg_write(2'd3, '0);
    wait_done(cyc);
    check("R8", "done after locked writes", int'(done), 1);
    check("R8", "reads kept count", n_rd, 4);
    check("R8", "writes kept count", n_wr, 4);
    check("R8", "addresses kept", n_order, 0);
    check("R9", "alternation/order errors", n_order, 0);
    for (int i = 0; i < 4; i++)
      check("R8", "dest word", int'(mem[220 + i]), 16'hC000 + i);
    cpu_mode = 0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_copy(0, 64, 1, 0);
    t_copy(8, 96, 8, 1);      // R10 select codes exercised here
    t_copy(30, 130, 16, 2);
    t_zero;
    t_copy(40, 160, 5, 2);
    t_lock;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule